// File: doc/BRIEF.md
# Multichannel Beam Loss Integrator Trip

This block watches a stream of time-multiplexed loss-monitor samples, one sample per clock at most, each tagged with the channel it belongs to. Every sample is handled as it arrives. The block subtracts the channel's programmed offset and clamps the result at zero. It then updates a sliding sum over the channel's most recent N corrected samples and compares that sum with the channel's limit. No whole waveform is collected before a decision is made, so a trip is known two clocks after the offending sample is accepted. That is far inside one 10 µs sample period of a 100 kHz, twelve-channel system.

A per-channel alarm vector shows which channels were above their limit at their latest evaluation. A single abort line is the latched OR of those alarms and drives the machine-protection input. A one-hot vector records the channel that caused the abort to latch. A simple write port loads offsets, limits and window lengths. A clear input releases the abort, but only once no channel is in alarm.

Top module: `blm_trip`

## Requirements
- R1: Each accepted sample has its channel's offset subtracted, as unsigned values. A negative difference counts as zero in the integral.
- R2: A channel's integral is the sum of its last N corrected samples. After a window write, the sum covers only the samples received since that write, up to N of them.
- R3: Window writes use cfg_sel = 2 and store N. A value of 0 is stored as 1, and a value above 16 is stored as 16. A window write restarts that channel's integral from zero. Offset writes use cfg_sel = 0 and take the low 16 bits. Limit writes use cfg_sel = 1 and take all 20 bits. Writes with cfg_sel = 3 change nothing.
- R4: alarm[c] is 1 exactly when channel c's integral at its latest sample is strictly greater than its limit. The bit is re-evaluated on every sample of that channel.
- R5: A sample presented at clock edge t changes alarm, abort and first_trip at edge t+2 and not at edge t+1.
- R6: abort rises when any channel's evaluation trips. It then stays high until clear is sampled high while the alarm vector is zero.
- R7: A clear sampled while any alarm bit is set is ignored, and abort stays high.
- R8: first_trip is one-hot with the channel that latched abort. Later trips leave it unchanged, and it returns to zero when abort clears.
- R9: The 20-bit integral is exact up to 16 × 65535. Such a sum compares correctly against both a limit just below it and the all-ones limit.
- R10: Samples with a channel index of 12 or more are ignored.
- R11: After reset, abort, alarm and first_trip are zero, offsets are 0, limits are all ones and windows are 16.

Note on R1: the offset is a baseline that is subtracted from the raw sample, and the clamp keeps offset noise from pulling the integral below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_chan | input | 4 | Channel index of the sample |
| s_data | input | 16 | Unsigned ADC sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 offset, 1 limit, 2 window, 3 none |
| cfg_chan | input | 4 | Channel being configured |
| cfg_wdata | input | 20 | Configuration value |
| clear | input | 1 | Request to release the abort |
| abort | output | 1 | Latched trip output |
| alarm | output | 12 | Per-channel current alarm |
| first_trip | output | 12 | One-hot channel that latched abort |

## Verification
The bench sweeps window values from 0 to 17 across all channels. It checks that the sum drops the oldest sample at the right point and covers only the samples since the last window write; a design with an off-by-one in the window or a stale history would trip early or late. Offset and sample pairs around equality check the zero clamp, since a design without it would wrap to large values and trip at once. Full-scale sums at window 16 compared with limits one below and at all ones catch an accumulator that is too narrow. A clear given during an alarm, a second trip after the first, and samples with invalid channel indices check that abort is not released early, that the recorded first channel is not overwritten, and that channel indices do not alias.

// File: rtl/blm_trip.sv
module blm_trip #(
  parameter int NCH  = 12,
  parameter int DW   = 16,
  parameter int MAXW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  input  logic [$clog2(NCH)-1:0]       s_chan,
  input  logic [DW-1:0]                s_data,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_sel,
  input  logic [$clog2(NCH)-1:0]       cfg_chan,
  input  logic [DW+$clog2(MAXW)-1:0]   cfg_wdata,
  input  logic                         clear,
  output logic                         abort,
  output logic [NCH-1:0]               alarm,
  output logic [NCH-1:0]               first_trip
);
  localparam int CW = $clog2(NCH);
  localparam int HW = $clog2(MAXW);
  localparam int WW = HW + 1;
  localparam int AW = DW + HW;

  logic [DW-1:0] offs [NCH];
  logic [AW-1:0] lim  [NCH];
  logic [WW-1:0] win  [NCH];
  logic [WW-1:0] fill [NCH];
  logic [HW-1:0] ptr  [NCH];
  logic [AW-1:0] acc  [NCH];
  logic [DW-1:0] hist [NCH*MAXW];

  logic          v1;
  logic [CW-1:0] c1;
  logic [DW-1:0] d1;

  wire          in_ok  = s_valid && (int'(s_chan) < NCH);
  wire          cfg_ok = cfg_we && (int'(cfg_chan) < NCH);
  wire [DW:0]   diff   = {1'b0, s_data} - {1'b0, offs[in_ok ? s_chan : '0]};
  wire [DW-1:0] corr   = diff[DW] ? '0 : diff[DW-1:0];

  wire [HW-1:0] rd_idx = ptr[c1] - win[c1][HW-1:0];
  wire          full   = fill[c1] >= win[c1];
  wire [DW-1:0] oldest = full ? hist[{c1, rd_idx}] : '0;
  wire [AW-1:0] nsum   = acc[c1] + AW'(d1) - AW'(oldest);
  wire          wclr   = cfg_ok && cfg_sel == 2'd2 && cfg_chan == c1;
  wire          upd    = v1 && !wclr;
  wire          trip   = upd && (nsum > lim[c1]);

  wire [WW-1:0] wnew = (cfg_wdata == '0) ? WW'(1) :
                       (cfg_wdata > AW'(MAXW)) ? WW'(MAXW) : cfg_wdata[WW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      c1 <= '0;
      d1 <= '0;
    end else begin
      v1 <= in_ok;
      c1 <= s_chan;
      d1 <= corr;
    end
  end

  always_ff @(posedge clk)
    if (upd) hist[{c1, ptr[c1]}] <= d1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        offs[i] <= '0;
        lim[i]  <= '1;
        win[i]  <= WW'(MAXW);
        fill[i] <= '0;
        ptr[i]  <= '0;
        acc[i]  <= '0;
      end
    end else begin
      if (upd) begin
        acc[c1] <= nsum;
        ptr[c1] <= ptr[c1] + 1'b1;
        if (fill[c1] < WW'(MAXW)) fill[c1] <= fill[c1] + 1'b1;
      end
      if (cfg_ok) begin
        case (cfg_sel)
          2'd0: offs[cfg_chan] <= cfg_wdata[DW-1:0];
          2'd1: lim[cfg_chan]  <= cfg_wdata;
          2'd2: begin
            win[cfg_chan]  <= wnew;
            acc[cfg_chan]  <= '0;
            fill[cfg_chan] <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm      <= '0;
      abort      <= 1'b0;
      first_trip <= '0;
    end else begin
      if (upd) alarm[c1] <= trip;
      if (trip) begin
        abort <= 1'b1;
        if (!abort) first_trip <= NCH'(1) << c1;
      end else if (clear && alarm == '0) begin
        abort      <= 1'b0;
        first_trip <= '0;
      end
    end
  end
endmodule

module blm_trip_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           clear,
  input logic           abort,
  input logic [NCH-1:0] alarm,
  input logic [NCH-1:0] first_trip
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !clear) |=> abort);

  p_clear_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && alarm != '0) |=> abort);

  p_alarm_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm != '0) |-> abort);

  p_first_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($countones(first_trip) == 1));

  p_first_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !abort |-> (first_trip == '0));

  p_first_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && $past(abort)) |-> $stable(first_trip));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> $past(s_valid, 2));
endmodule

bind blm_trip blm_trip_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .clear(clear),
  .abort(abort), .alarm(alarm), .first_trip(first_trip)
);

// File: tb/blm_trip_tb.sv
module blm_trip_tb;
  localparam int NCH = 12;

  logic        clk = 0, rst_n = 0;
  logic        s_valid = 0;
  logic [3:0]  s_chan = 0;
  logic [15:0] s_data = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [3:0]  cfg_chan = 0;
  logic [19:0] cfg_wdata = 0;
  logic        clear = 0;
  logic        abort;
  logic [11:0] alarm, first_trip;

  blm_trip u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  longint mbase [NCH], mthr [NCH];
  int     mwin [NCH], mcnt [NCH];
  longint ring [NCH][16];
  logic [11:0] malarm = 0, mfirst = 0;
  logic        mabort = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint esum(int ch);
    longint s = 0;
    int n = (mcnt[ch] < mwin[ch]) ? mcnt[ch] : mwin[ch];
    for (int i = 0; i < n; i++) s += ring[ch][(mcnt[ch] - 1 - i) % 16];
    return s;
  endfunction

  task automatic cfg(int sel, int ch, longint val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_chan = 4'(ch); cfg_wdata = 20'(val);
    @(negedge clk);
    cfg_we = 0;
    if (ch < NCH) begin
      if (sel == 0) mbase[ch] = val & 16'hffff;
      if (sel == 1) mthr[ch] = val;
      if (sel == 2) begin
        mwin[ch] = (val == 0) ? 1 : (val > 16) ? 16 : int'(val);
        mcnt[ch] = 0;
      end
    end
  endtask

  task automatic send(int ch, longint d, string req);
    logic [11:0] a0 = alarm;
    logic        b0 = abort;
    logic [11:0] f0 = first_trip;
    @(negedge clk);
    s_valid = 1; s_chan = 4'(ch); s_data = 16'(d);
    @(negedge clk);
    s_valid = 0;
    chk("R5 alarm not yet", alarm, a0);
    chk("R5 abort not yet", abort, b0);
    chk("R5 first not yet", first_trip, f0);
    if (ch < NCH) begin
      longint c = d - mbase[ch];
      if (c < 0) c = 0;
      ring[ch][mcnt[ch] % 16] = c;
      mcnt[ch]++;
      malarm[ch] = esum(ch) > mthr[ch];
      if (malarm[ch]) begin
        if (!mabort) mfirst = 12'(1) << ch;
        mabort = 1;
      end
    end
    @(negedge clk);
    chk({req, " alarm"}, alarm, malarm);
    chk({req, " abort R6"}, abort, mabort);
    chk({req, " first R8"}, first_trip, mfirst);
  endtask

  task automatic do_clear(string req);
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
    if (malarm == 0) begin mabort = 0; mfirst = 0; end
    chk({req, " abort"}, abort, mabort);
    chk({req, " first"}, first_trip, mfirst);
  endtask

  task automatic settle();
    for (int c = 0; c < NCH; c++) begin
      cfg(1, c, 20'hfffff);
      if (malarm[c]) send(c, 0, "R4 settle");
    end
    do_clear("R6 settle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mbase[c] = 0; mthr[c] = 20'hfffff; mwin[c] = 16; mcnt[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 abort", abort, 0);
    chk("R11 alarm", alarm, 0);
    chk("R11 first", first_trip, 0);

    // R9 and R11: full-scale sums, default limit and window
    for (int k = 0; k < 17; k++) send(0, 65535, "R9 fullscale");
    cfg(1, 0, 1048559);
    send(0, 65535, "R9 limit below");
    chk("R9 alarm set", alarm[0], 1);
    do_clear("R7 blocked");
    chk("R7 abort held", abort, 1);
    settle();
    chk("R6 released", abort, 0);

    // R1: offset sweep, window 1
    cfg(2, 1, 1);
    foreach (mbase[i]) ;
    for (int bi = 0; bi < 4; bi++) begin
      for (int di = 0; di < 6; di++) begin
        longint bv [4] = '{0, 1, 1000, 65535};
        longint dv [6] = '{0, 1, 999, 1000, 1001, 65535};
        cfg(0, 1, bv[bi]);
        cfg(1, 1, (dv[di] > bv[bi]) ? dv[di] - bv[bi] - 1 : 0);
        send(1, dv[di], "R1 offset");
        cfg(1, 1, (dv[di] > bv[bi]) ? dv[di] - bv[bi] : 0);
        send(1, dv[di], "R1 exact");
      end
    end
    settle();

    // R2, R3, R4: window sweep across channels
    for (int w = 0; w < 18; w++) begin
      int ch = w % NCH;
      int en = (w == 0) ? 1 : (w > 16) ? 16 : w;
      cfg(0, ch, 100);
      cfg(2, ch, w);
      cfg(1, ch, 45 * en);
      for (int k = 0; k < 20; k++)
        send(ch, 80 + ((k * 37 + w * 11) % 90), "R2 window");
      settle();
    end
    cfg(3, 2, 5);
    cfg(1, 2, 0);
    send(2, 101, "R3 sel3 ignored");
    settle();

    // R8: second trip leaves first_trip
    cfg(0, 3, 0); cfg(2, 3, 2); cfg(1, 3, 10);
    cfg(0, 5, 0); cfg(2, 5, 2); cfg(1, 5, 10);
    send(3, 20, "R8 first trip");
    send(5, 20, "R8 second trip");
    chk("R8 first is ch3", first_trip, 12'h008);
    settle();

    // R10: invalid channel indices with every limit at zero
    for (int c = 0; c < NCH; c++) cfg(1, c, 0);
    for (int c = NCH; c < 16; c++) send(c, 65535, "R10 ignored");
    chk("R10 no alarm", alarm, 0);
    settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule